// File: doc/BRIEF.md
# Slow Shutter Accumulation Controller

This block runs a long-exposure mode in a sensor video pipeline. For a programmed accumulation length of N frames it holds the sensor readout pulse off for N-1 frame periods, so that charge keeps building on the sensor. While the pulse is held off, the block drives its live-path enable low to cut the upstream pixel stage off from the downstream processor. During those frames it replays the last captured frame from an internal one-frame store, so the output keeps carrying pictures.

At the end of the window the readout pulse is released and the live path comes back on together. The frame then read out is passed straight through and written into the store. The cycle then repeats. All sequencing happens on frame-sync boundaries. A length of 0 or 1 gives plain live operation. A new length is taken up only at a release point.

Top module: `slowexp_ctrl`

## Requirements
- R1: While `live_en_o` is low, `rd_pulse_o` is held at its inactive level (low with the default active-high polarity) whatever `rd_pulse_i` does. While `live_en_o` is high, `rd_pulse_o` equals `rd_pulse_i` in the same cycle.
- R2: With an effective length N ≥ 2, `live_en_o` is high for the first frame after each release sync and low for the following N-1 frames. The next release sync then comes, and the pattern repeats.
- R3: In a frame with `live_en_o` low, the k-th accepted input cycle of the frame (k counted from 0) produces, one cycle later, `pix_valid_o` high and `pix_o` equal to the stored pixel at raster position k.
- R4: In a frame with `live_en_o` high, each accepted input pixel appears on `pix_o` with `pix_valid_o` high exactly one cycle later.
- R5: Every live frame that follows a sync is written into the store at raster positions 0, 1, 2… in arrival order. Positions not rewritten keep older data. Pixels beyond FRAME_W×FRAME_H are not stored, and a replay past the end returns the last position.
- R6: An accumulation length of 0 or 1 keeps `live_en_o` high through every frame, and `rd_pulse_o` follows `rd_pulse_i`.
- R7: `live_en_o` changes only in the cycle after a `frame_sync_i` pulse.
- R8: `accum_len_i` is sampled only on a release sync (the sync that ends the last frame of a cycle). Changes at other times do not alter the cycle in progress.
- R9: After reset, `live_en_o` is high and `pix_valid_o` is low. The store is treated as empty until one full live frame has been captured after a sync, and no replay occurs before that.
- R10: A cycle with `frame_sync_i` high accepts no pixel. `pix_valid_o` is low in the following cycle, even if `pix_valid_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | One-cycle pulse at the start of each frame |
| pix_i | input | DATA_W | Live pixel data |
| pix_valid_i | input | 1 | Live pixel valid / raster timing strobe |
| rd_pulse_i | input | 1 | Sensor readout pulse from the timing generator |
| accum_len_i | input | LEN_W | Accumulation length in frames |
| rd_pulse_o | output | 1 | Gated readout pulse to the sensor |
| live_en_o | output | 1 | Live path enable (high = upstream connected) |
| pix_o | output | DATA_W | Output pixel (live or replayed) |
| pix_valid_o | output | 1 | Output pixel valid |

## Verification
A frame sync moves `live_en_o`, and the readout gate with it, one clock edge later. `rd_pulse_o` follows `rd_pulse_i` in the same cycle with no register between them. Every pixel result, live or replayed, is due exactly one edge after its input cycle. The bench keeps a behavioural model that advances on each rising edge with the same inputs the design sees. It compares all four outputs at the falling edge, after the registers have settled and before any new stimulus. Readout-pulse checks are made against the input value of that same cycle, and pixel checks against the input of the cycle before.

// File: rtl/slowexp_pkg.sv
package slowexp_pkg;
   typedef enum logic {
      SRC_STORE = 1'b0,
      SRC_LIVE  = 1'b1
   } src_e;

   function automatic int unsigned depth_of(input int unsigned w, input int unsigned h);
      return w * h;
   endfunction
endpackage

// File: rtl/slowexp_seq.sv
module slowexp_seq #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_sync_i,
   input  logic [LEN_W-1:0] accum_len_i,
   output logic             live_o,
   output logic             capture_o
);
   logic [LEN_W-1:0] ph_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] last_ph;
   logic             armed_q;
   logic             stored_q;
   logic             at_release;

   always_comb begin
      last_ph    = (len_q == '0) ? '0 : len_q - LEN_W'(1);
      at_release = (ph_q >= last_ph);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= '0;
         len_q    <= LEN_W'(1);
         armed_q  <= 1'b0;
         stored_q <= 1'b0;
      end else if (frame_sync_i) begin
         armed_q <= 1'b1;
         if (ph_q == '0 && armed_q) begin
            stored_q <= 1'b1;
         end
         if (at_release) begin
            ph_q  <= '0;
            len_q <= accum_len_i;
         end else begin
            ph_q <= ph_q + LEN_W'(1);
         end
      end
   end

   assign live_o    = (ph_q == '0);
   assign capture_o = live_o & armed_q;

   p_sync_only_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(live_o) |-> $past(frame_sync_i));

   p_short_live_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync_i && len_q <= LEN_W'(1)) |=> live_o);

   p_replay_stored_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !live_o |-> stored_q);

   p_phase_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ph_q <= last_ph);
endmodule

// File: rtl/slowexp_raster.sv
module slowexp_raster #(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_i,
   input  logic          step_i,
   output logic [AW-1:0] addr_o,
   output logic          in_range_o
);
   logic [CW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (sync_i) begin
         pos_q <= '0;
      end else if (step_i && in_range_o) begin
         pos_q <= pos_q + CW'(1);
      end
   end

   always_comb begin
      in_range_o = (pos_q < CW'(DEPTH));
      addr_o     = in_range_o ? pos_q[AW-1:0] : AW'(DEPTH - 1);
   end

   p_addr_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= CW'(DEPTH));
endmodule

// File: rtl/slowexp_fbuf.sv
module slowexp_fbuf #(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         mem[addr_i] <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= '0;
      end else if (rd_en_i) begin
         rd_data_o <= mem[addr_i];
      end
   end

   p_no_rw_clash_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && rd_en_i));
endmodule

// File: rtl/slowexp_ctrl.sv
module slowexp_ctrl
   import slowexp_pkg::*;
#(
   parameter int DATA_W         = 10,
   parameter int FRAME_W        = 8,
   parameter int FRAME_H        = 4,
   parameter int LEN_W          = 4,
   parameter bit RD_ACTIVE_HIGH = 1'b1,
   localparam int DEPTH = int'(depth_of(FRAME_W, FRAME_H)),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync_i,
   input  logic [DATA_W-1:0] pix_i,
   input  logic              pix_valid_i,
   input  logic              rd_pulse_i,
   input  logic [LEN_W-1:0]  accum_len_i,
   output logic              rd_pulse_o,
   output logic              live_en_o,
   output logic [DATA_W-1:0] pix_o,
   output logic              pix_valid_o
);
   if (DATA_W < 1) begin : g_bad_data
      $error("slowexp_ctrl: DATA_W must be at least 1");
   end
   if (FRAME_W < 2 || FRAME_H < 1) begin : g_bad_frame
      $error("slowexp_ctrl: frame must hold at least two pixels");
   end
   if (DEPTH > 4096) begin : g_bad_depth
      $error("slowexp_ctrl: frame store larger than 4096 entries");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("slowexp_ctrl: LEN_W must be at least 2");
   end

   logic              live;
   logic              capture;
   logic              accept;
   logic [AW-1:0]     addr;
   logic              in_range;
   logic              wr_en;
   logic              rd_en;
   logic [DATA_W-1:0] store_q;
   logic [DATA_W-1:0] live_pix_q;
   src_e              src_q;

   slowexp_seq #(.LEN_W(LEN_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_sync_i (frame_sync_i),
      .accum_len_i  (accum_len_i),
      .live_o       (live),
      .capture_o    (capture)
   );

   assign accept = pix_valid_i & ~frame_sync_i;

   slowexp_raster #(.DEPTH(DEPTH)) u_raster (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (frame_sync_i),
      .step_i     (accept),
      .addr_o     (addr),
      .in_range_o (in_range)
   );

   assign wr_en = accept & capture & in_range;
   assign rd_en = accept & ~live;

   slowexp_fbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr),
      .wr_en_i   (wr_en),
      .wr_data_i (pix_i),
      .rd_en_i   (rd_en),
      .rd_data_o (store_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_pix_q  <= '0;
         src_q       <= SRC_LIVE;
         pix_valid_o <= 1'b0;
      end else begin
         live_pix_q  <= pix_i;
         src_q       <= live ? SRC_LIVE : SRC_STORE;
         pix_valid_o <= accept;
      end
   end

   assign pix_o     = (src_q == SRC_LIVE) ? live_pix_q : store_q;
   assign live_en_o = live;

   if (RD_ACTIVE_HIGH) begin : g_gate_hi
      assign rd_pulse_o = rd_pulse_i & live;
      p_gate_closed_r1 : assert property (@(posedge clk) disable iff (!rst_n)
         !live_en_o |-> !rd_pulse_o);
   end else begin : g_gate_lo
      assign rd_pulse_o = rd_pulse_i | ~live;
      p_gate_closed_r1 : assert property (@(posedge clk) disable iff (!rst_n)
         !live_en_o |-> rd_pulse_o);
   end

   p_valid_latency_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_o |-> $past(pix_valid_i));

   p_sync_drop_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync_i |=> !pix_valid_o);
endmodule

// File: tb/tb_slowexp_ctrl.sv
module tb_slowexp_ctrl;
   localparam int DATA_W = 10;
   localparam int FRAME_W = 8;
   localparam int FRAME_H = 4;
   localparam int LEN_W = 4;
   localparam int DEPTH = FRAME_W * FRAME_H;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_sync_i = 1'b0;
   logic [DATA_W-1:0] pix_i = '0;
   logic              pix_valid_i = 1'b0;
   logic              rd_pulse_i = 1'b0;
   logic [LEN_W-1:0]  accum_len_i = '0;
   logic              rd_pulse_o;
   logic              live_en_o;
   logic [DATA_W-1:0] pix_o;
   logic              pix_valid_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   slowexp_ctrl #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
                  .LEN_W(LEN_W), .RD_ACTIVE_HIGH(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync_i), .pix_i(pix_i),
      .pix_valid_i(pix_valid_i), .rd_pulse_i(rd_pulse_i), .accum_len_i(accum_len_i),
      .rd_pulse_o(rd_pulse_o), .live_en_o(live_en_o), .pix_o(pix_o),
      .pix_valid_o(pix_valid_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_ph, m_len, m_addr;
   bit m_armed, m_vld;
   int m_pix;
   int m_mem [DEPTH];
   bit prev_sync;
   bit prev_live;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_len = 1; m_addr = 0; m_armed = 0; m_vld = 0; m_pix = 0;
         foreach (m_mem[i]) m_mem[i] = 0;
      end else begin
         int len_eff;
         bit acc;
         acc = pix_valid_i && !frame_sync_i;
         m_vld = acc;
         if (acc) begin
            if (m_ph == 0) begin
               m_pix = int'(pix_i);
               if (m_armed && m_addr < DEPTH) m_mem[m_addr] = int'(pix_i);
            end else begin
               m_pix = m_mem[(m_addr < DEPTH) ? m_addr : DEPTH - 1];
            end
         end
         if (frame_sync_i) begin
            m_addr = 0;
            m_armed = 1;
            len_eff = (m_len == 0) ? 1 : m_len;
            if (m_ph >= len_eff - 1) begin
               m_ph = 0;
               m_len = int'(accum_len_i);
            end else begin
               m_ph++;
            end
         end else if (acc && m_addr < DEPTH) begin
            m_addr++;
         end
      end
   end

   // compare every cycle at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_live;
         bit exp_rd;
         exp_live = (m_ph == 0);
         exp_rd = rd_pulse_i && exp_live;
         chk(live_en_o == exp_live, "R2 R8 live enable", int'(live_en_o), int'(exp_live));
         chk(rd_pulse_o == exp_rd, exp_live ? "R1 R6 readout pass" : "R1 readout blocked",
             int'(rd_pulse_o), int'(exp_rd));
         chk(pix_valid_o == m_vld, "R10 R4 output valid", int'(pix_valid_o), int'(m_vld));
         if (m_vld && pix_valid_o) begin
            chk(int'(pix_o) == m_pix, exp_live ? "R4 live pixel" : "R3 R5 replay pixel",
                int'(pix_o), m_pix);
         end
         if (live_en_o != prev_live) begin
            chk(prev_sync, "R7 change without sync", int'(live_en_o), int'(prev_live));
         end
      end
      prev_live = live_en_o;
      prev_sync = frame_sync_i;
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // one frame: sync cycle, pixels with optional gaps, blanking
   task automatic frame(input int npix, input int base, input int gap, input bit valid_on_sync);
      int sent;
      int cyc;
      step();
      frame_sync_i = 1'b1;
      pix_valid_i = valid_on_sync;
      pix_i = DATA_W'(base + 999);
      rd_pulse_i = 1'b1;
      step();
      frame_sync_i = 1'b0;
      sent = 0;
      cyc = 0;
      while (sent < npix) begin
         rd_pulse_i = (cyc % 7 == 2);
         if (gap != 0 && cyc % gap == gap - 1) begin
            pix_valid_i = 1'b0;
         end else begin
            pix_valid_i = 1'b1;
            pix_i = DATA_W'(base + sent * 3);
            sent++;
         end
         cyc++;
         step();
      end
      pix_valid_i = 1'b0;
      rd_pulse_i = 1'b1;
      step();
      rd_pulse_i = 1'b0;
      step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      accum_len_i = LEN_W'(1);
      @(negedge clk);
      chk(live_en_o == 1'b1, "R9 reset live", int'(live_en_o), 1);
      chk(pix_valid_o == 1'b0, "R9 reset valid", int'(pix_valid_o), 0);
      // R6: length 1, plain live operation
      frame(DEPTH, 10, 0, 1'b0);
      frame(DEPTH, 50, 4, 1'b1);
      accum_len_i = LEN_W'(3);          // taken at the next sync (release)
      frame(DEPTH, 90, 0, 1'b0);
      // R2: three-frame cycles
      frame(DEPTH, 130, 5, 1'b0);
      frame(DEPTH, 170, 0, 1'b1);
      frame(DEPTH, 210, 3, 1'b0);
      accum_len_i = LEN_W'(2);          // R8: mid-cycle change
      frame(DEPTH, 250, 0, 1'b0);
      frame(DEPTH, 290, 0, 1'b0);
      frame(DEPTH, 330, 6, 1'b0);
      frame(DEPTH, 370, 0, 1'b0);
      accum_len_i = LEN_W'(4);
      frame(DEPTH - 12, 410, 0, 1'b0);  // R5: short capture
      frame(DEPTH + 2, 450, 0, 1'b0);   // R5: overrun on replay
      frame(DEPTH, 490, 4, 1'b0);
      frame(DEPTH, 530, 0, 1'b0);
      frame(DEPTH + 3, 570, 0, 1'b0);
      frame(DEPTH, 610, 2, 1'b1);
      frame(DEPTH, 650, 0, 1'b0);
      accum_len_i = LEN_W'(0);          // R6: zero behaves as one
      frame(DEPTH, 690, 0, 1'b0);
      frame(DEPTH, 730, 0, 1'b0);
      frame(DEPTH, 770, 3, 1'b0);
      frame(DEPTH, 810, 0, 1'b0);
      frame(DEPTH, 850, 0, 1'b0);
      step();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule